// File: doc/BRIEF.md
# Programmable Interlaced Raster Timing Generator

This block walks a pixel position across a raster and derives the line and frame timing signals a display pipeline needs: pixel and line counters, an active-video enable, horizontal and vertical sync, a field flag and a one-cycle start-of-frame pulse. It covers progressive scan and two-field interlaced scan. Every boundary of the raster is supplied as a parameter word on input ports: raster size, first active column, per-field blanking lines, the first line of each field, the horizontal sync columns, and vertical sync edges given as a (column, line) pair so that vertical sync can change in the middle of a line.

Configuration words on the inputs are not used directly. A commit strobe copies them into a pending bank, and the pending bank moves into the working bank only on the last pixel of a frame. A raster therefore never mixes old and new settings. After reset the generator stays idle at position (0,0) until the first commit, which is taken at once.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is low, and after reset until the first commit, h_pos and v_pos are 0 and de, hsync, vsync, field and sof are all 0.
- R2: A commit sampled while idle loads the configuration in that same clock edge; in the following cycle sof is 1 at position (0,0), and counting continues from there.
- R3: While running, h_pos steps by 1 each cycle and returns to 0 after cfg_h_total-1; v_pos steps by 1 when h_pos wraps and returns to 0 after cfg_v_total-1; sof is 1 exactly when the position is (0,0).
- R4: de is 1 when h_pos >= cfg_h_act_start and the line is not a vertical blanking line.
- R5: A line is a blanking line when cfg_vb1_start <= v_pos < cfg_vb1_end, or, in interlaced mode only, when cfg_vb2_start <= v_pos < cfg_vb2_end.
- R6: hsync is 1 when cfg_hs_start <= h_pos < cfg_hs_end, on every line.
- R7: For each field window, vsync is 1 from the position (on_col, on_line) inclusive to (off_col, off_line) exclusive, positions ordered by line then column; the field 2 window is used only in interlaced mode.
- R8: In interlaced mode field is 1 when v_pos >= cfg_f2_first or v_pos < cfg_f1_first, else 0; with cfg_progressive = 1 field is always 0.
- R9: Changing configuration inputs without a commit has no effect on the generated raster.
- R10: A commit while running is held as pending and applied on the last pixel of the current frame, so the next frame starts with it; of several commits in one frame the last one wins; a commit sampled on the last pixel of a frame is applied one frame later, while the already-pending settings are applied at that boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_h_total | input | HW | Pixels per line |
| cfg_h_act_start | input | HW | First active column |
| cfg_hs_start | input | HW | Column where hsync rises |
| cfg_hs_end | input | HW | Column where hsync falls |
| cfg_vs1_on_col | input | HW | Field 1 vsync start column |
| cfg_vs1_off_col | input | HW | Field 1 vsync end column |
| cfg_vs2_on_col | input | HW | Field 2 vsync start column |
| cfg_vs2_off_col | input | HW | Field 2 vsync end column |
| cfg_v_total | input | VW | Lines per frame (both fields) |
| cfg_vb1_start | input | VW | Field 1 first blanking line |
| cfg_vb1_end | input | VW | Line after field 1 blanking |
| cfg_vb2_start | input | VW | Field 2 first blanking line |
| cfg_vb2_end | input | VW | Line after field 2 blanking |
| cfg_f1_first | input | VW | First line of field 1 |
| cfg_f2_first | input | VW | First line of field 2 |
| cfg_vs1_on_line | input | VW | Field 1 vsync start line |
| cfg_vs1_off_line | input | VW | Field 1 vsync end line |
| cfg_vs2_on_line | input | VW | Field 2 vsync start line |
| cfg_vs2_off_line | input | VW | Field 2 vsync end line |
| cfg_progressive | input | 1 | 1 selects progressive scan |
| cfg_commit | input | 1 | One-cycle strobe capturing the configuration |
| h_pos | output | HW | Current column |
| v_pos | output | VW | Current line |
| de | output | 1 | Active video enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| field | output | 1 | 0 for field 1, 1 for field 2 |
| sof | output | 1 | Start-of-frame pulse at (0,0) |

## Verification
The two functions that can coincide are the swap of the pending bank into the working bank at the end of a frame and the capture of a fresh commit into the pending bank. The bench commits one setting in the middle of a frame, waits until the outputs show the last pixel of that frame, and strobes a second, different commit in exactly that cycle. It then judges the outcome by frame length between start-of-frame pulses (the first setting's size, then the second's) and by a cycle-by-cycle comparison of every output against an independent model of the requirements.

// File: rtl/rt_pkg.sv
// Package: shared field indices for the raster timing generator.
// The configuration travels as one flat word: horizontal fields first
// (index 0 at the LSB), then vertical fields, then the mode bit on top.
package rt_pkg;
    localparam int N_HF = 8;
    localparam int N_VF = 11;

    localparam int HF_TOTAL   = 0;
    localparam int HF_ACT     = 1;
    localparam int HF_HS_ON   = 2;
    localparam int HF_HS_OFF  = 3;
    localparam int HF_VS1_ON  = 4;
    localparam int HF_VS1_OFF = 5;
    localparam int HF_VS2_ON  = 6;
    localparam int HF_VS2_OFF = 7;

    localparam int VF_TOTAL   = 0;
    localparam int VF_B1_ON   = 1;
    localparam int VF_B1_OFF  = 2;
    localparam int VF_B2_ON   = 3;
    localparam int VF_B2_OFF  = 4;
    localparam int VF_F1      = 5;
    localparam int VF_F2      = 6;
    localparam int VF_VS1_ON  = 7;
    localparam int VF_VS1_OFF = 8;
    localparam int VF_VS2_ON  = 9;
    localparam int VF_VS2_OFF = 10;
endpackage

// File: rtl/rt_shadow.sv
// Module: rt_shadow
// Two-stage configuration bank. A commit while idle loads the working
// bank directly and starts the generator. A commit while running lands in
// the pending bank, which moves to the working bank on the frame's last
// pixel. Assumes commit is a one-cycle strobe.
module rt_shadow #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         commit,
    input  logic         frame_end,
    input  logic [W-1:0] cfg_in,
    output logic [W-1:0] work,
    output logic         running
);
    logic [W-1:0] pend;
    logic         pend_v;

    // Bank update: start on first commit, else capture pending and swap at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            work    <= '0;
            pend    <= '0;
            pend_v  <= 1'b0;
            running <= 1'b0;
        end else if (!running) begin
            if (commit) begin
                work    <= cfg_in;
                running <= 1'b1;
            end
        end else begin
            if (frame_end && pend_v) begin
                work   <= pend;
                pend_v <= 1'b0;
            end
            if (commit) begin
                pend   <= cfg_in;
                pend_v <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/rt_counter.sv
// Module: rt_counter
// Column and line counters of the raster. Both hold at 0 while disabled.
// Assumes totals of at least 2 so that each wrap point is reachable.
module rt_counter #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [HW-1:0] h_total,
    input  logic [VW-1:0] v_total,
    output logic [HW-1:0] h,
    output logic [VW-1:0] v,
    output logic          frame_end
);
    logic h_last;
    logic v_last;

    // Wrap detection against the working totals.
    always_comb begin
        h_last    = (h == h_total - 1'b1);
        v_last    = (v == v_total - 1'b1);
        frame_end = en && h_last && v_last;
    end

    // Column/line stepping with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h <= '0;
            v <= '0;
        end else if (en) begin
            if (h_last) begin
                h <= '0;
                v <= v_last ? '0 : v + 1'b1;
            end else begin
                h <= h + 1'b1;
            end
        end
    end
endmodule

// File: rtl/rt_decode.sv
// Module: rt_decode
// Combinational decode of the raster position into timing outputs.
// Index 0 of each per-field pair is field 1, index 1 is field 2. Field 2
// entries are masked in progressive mode. Ranges do not wrap.
module rt_decode #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic                 running,
    input  logic                 prog,
    input  logic [HW-1:0]        h,
    input  logic [VW-1:0]        v,
    input  logic [HW-1:0]        h_act,
    input  logic [HW-1:0]        hs_on,
    input  logic [HW-1:0]        hs_off,
    input  logic [VW-1:0]        f1_first,
    input  logic [VW-1:0]        f2_first,
    input  logic [1:0][VW-1:0]   vb_on,
    input  logic [1:0][VW-1:0]   vb_off,
    input  logic [1:0][HW-1:0]   vs_on_h,
    input  logic [1:0][VW-1:0]   vs_on_v,
    input  logic [1:0][HW-1:0]   vs_off_h,
    input  logic [1:0][VW-1:0]   vs_off_v,
    output logic                 de,
    output logic                 hsync,
    output logic                 vsync,
    output logic                 field,
    output logic                 sof
);
    logic [1:0] blank;
    logic [1:0] win;
    logic [1:0] use_f;

    assign use_f = {~prog, 1'b1};

    for (genvar f = 0; f < 2; f++) begin : g_field
        logic past_on;
        logic before_off;
        // Per-field blanking line range and (column,line) sync window.
        always_comb begin
            blank[f]   = (v >= vb_on[f]) && (v < vb_off[f]);
            past_on    = (v > vs_on_v[f]) || ((v == vs_on_v[f]) && (h >= vs_on_h[f]));
            before_off = (v < vs_off_v[f]) || ((v == vs_off_v[f]) && (h < vs_off_h[f]));
            win[f]     = past_on && before_off;
        end
    end

    // Output gating by run state and mode.
    always_comb begin
        de    = running && (h >= h_act) && !(|(blank & use_f));
        hsync = running && (h >= hs_on) && (h < hs_off);
        vsync = running && (|(win & use_f));
        field = running && !prog && ((v >= f2_first) || (v < f1_first));
        sof   = running && (h == '0) && (v == '0);
    end
endmodule

// File: rtl/raster_timing_gen.sv
// Module: raster_timing_gen (top)
// Programmable progressive/interlaced raster timing generator. Packs the
// configuration inputs into one word, banks it through rt_shadow, counts
// with rt_counter and decodes outputs with rt_decode.
// Assumes: totals >= 2, start <= end for every range, no range wraps.
module raster_timing_gen #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [HW-1:0] cfg_h_total,
    input  logic [HW-1:0] cfg_h_act_start,
    input  logic [HW-1:0] cfg_hs_start,
    input  logic [HW-1:0] cfg_hs_end,
    input  logic [HW-1:0] cfg_vs1_on_col,
    input  logic [HW-1:0] cfg_vs1_off_col,
    input  logic [HW-1:0] cfg_vs2_on_col,
    input  logic [HW-1:0] cfg_vs2_off_col,
    input  logic [VW-1:0] cfg_v_total,
    input  logic [VW-1:0] cfg_vb1_start,
    input  logic [VW-1:0] cfg_vb1_end,
    input  logic [VW-1:0] cfg_vb2_start,
    input  logic [VW-1:0] cfg_vb2_end,
    input  logic [VW-1:0] cfg_f1_first,
    input  logic [VW-1:0] cfg_f2_first,
    input  logic [VW-1:0] cfg_vs1_on_line,
    input  logic [VW-1:0] cfg_vs1_off_line,
    input  logic [VW-1:0] cfg_vs2_on_line,
    input  logic [VW-1:0] cfg_vs2_off_line,
    input  logic          cfg_progressive,
    input  logic          cfg_commit,
    output logic [HW-1:0] h_pos,
    output logic [VW-1:0] v_pos,
    output logic          de,
    output logic          hsync,
    output logic          vsync,
    output logic          field,
    output logic          sof
);
    import rt_pkg::*;

    localparam int VBASE = N_HF * HW;
    localparam int CFG_W = VBASE + N_VF * VW + 1;

    logic [CFG_W-1:0] cfg_in;
    logic [CFG_W-1:0] work;
    logic             running;
    logic             frame_end;
    logic [HW-1:0]    w_h [N_HF];
    logic [VW-1:0]    w_v [N_VF];
    logic [HW-1:0]    w_htot;
    logic [VW-1:0]    w_vtot;
    logic             w_prog;

    assign cfg_in = {cfg_progressive,
                     cfg_vs2_off_line, cfg_vs2_on_line, cfg_vs1_off_line, cfg_vs1_on_line,
                     cfg_f2_first, cfg_f1_first,
                     cfg_vb2_end, cfg_vb2_start, cfg_vb1_end, cfg_vb1_start, cfg_v_total,
                     cfg_vs2_off_col, cfg_vs2_on_col, cfg_vs1_off_col, cfg_vs1_on_col,
                     cfg_hs_end, cfg_hs_start, cfg_h_act_start, cfg_h_total};

    for (genvar i = 0; i < N_HF; i++) begin : g_hf
        assign w_h[i] = work[i*HW +: HW];
    end
    for (genvar j = 0; j < N_VF; j++) begin : g_vf
        assign w_v[j] = work[VBASE + j*VW +: VW];
    end

    assign w_htot = w_h[HF_TOTAL];
    assign w_vtot = w_v[VF_TOTAL];
    assign w_prog = work[CFG_W-1];

    rt_shadow #(.W(CFG_W)) u_shadow (
        .clk       (clk),
        .rst_n     (rst_n),
        .commit    (cfg_commit),
        .frame_end (frame_end),
        .cfg_in    (cfg_in),
        .work      (work),
        .running   (running)
    );

    rt_counter #(.HW(HW), .VW(VW)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (running),
        .h_total   (w_htot),
        .v_total   (w_vtot),
        .h         (h_pos),
        .v         (v_pos),
        .frame_end (frame_end)
    );

    rt_decode #(.HW(HW), .VW(VW)) u_decode (
        .running  (running),
        .prog     (w_prog),
        .h        (h_pos),
        .v        (v_pos),
        .h_act    (w_h[HF_ACT]),
        .hs_on    (w_h[HF_HS_ON]),
        .hs_off   (w_h[HF_HS_OFF]),
        .f1_first (w_v[VF_F1]),
        .f2_first (w_v[VF_F2]),
        .vb_on    ({w_v[VF_B2_ON],   w_v[VF_B1_ON]}),
        .vb_off   ({w_v[VF_B2_OFF],  w_v[VF_B1_OFF]}),
        .vs_on_h  ({w_h[HF_VS2_ON],  w_h[HF_VS1_ON]}),
        .vs_on_v  ({w_v[VF_VS2_ON],  w_v[VF_VS1_ON]}),
        .vs_off_h ({w_h[HF_VS2_OFF], w_h[HF_VS1_OFF]}),
        .vs_off_v ({w_v[VF_VS2_OFF], w_v[VF_VS1_OFF]}),
        .de       (de),
        .hsync    (hsync),
        .vsync    (vsync),
        .field    (field),
        .sof      (sof)
    );
endmodule

// File: rtl/raster_timing_gen_chk.sv
// Module: raster_timing_gen_chk
// Temporal checks on the generator, attached to every instance by bind.
module raster_timing_gen_chk #(
    parameter int HW = 12,
    parameter int VW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          running,
    input logic          commit,
    input logic          prog,
    input logic [HW-1:0] wk_h_total,
    input logic [HW-1:0] h_pos,
    input logic [VW-1:0] v_pos,
    input logic          de,
    input logic          hsync,
    input logic          vsync,
    input logic          field,
    input logic          sof
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (h_pos == '0 && v_pos == '0 && !de && !hsync && !vsync && !field && !sof));

    // R2
    first_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && commit) |=> (running && sof));

    // R3
    h_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && h_pos != wk_h_total - 1'b1) |=> (h_pos == $past(h_pos) + 1'b1));

    // R3
    h_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && h_pos == wk_h_total - 1'b1) |=> (h_pos == '0));

    // R3
    v_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && h_pos != wk_h_total - 1'b1) |=> $stable(v_pos));

    // R3
    sof_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sof |=> !sof);

    // R8
    prog_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog |-> !field);
endmodule

bind raster_timing_gen raster_timing_gen_chk #(.HW(HW), .VW(VW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .running    (running),
    .commit     (cfg_commit),
    .prog       (w_prog),
    .wk_h_total (w_htot),
    .h_pos      (h_pos),
    .v_pos      (v_pos),
    .de         (de),
    .hsync      (hsync),
    .vsync      (vsync),
    .field      (field),
    .sof        (sof)
);

// File: tb/raster_timing_gen_bench.sv
// Scoreboard bench: a reference model of the requirements pushes the
// expected outputs of each cycle into a queue; a monitor pops and compares.
module raster_timing_gen_bench;
    localparam int  HW = 12;
    localparam int  VW = 11;
    localparam time CLK_P = 8ns;

    typedef struct packed {
        int ht; int vt; int act; int hs_on; int hs_off;
        int b1s; int b1e; int b2s; int b2e; int f1; int f2;
        int v1oh; int v1ov; int v1fh; int v1fv;
        int v2oh; int v2ov; int v2fh; int v2fv;
        int prog;
    } cfg_t;

    typedef struct {
        int h; int v; bit de; bit hs; bit vs; bit fld; bit sof;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic commit = 1'b0;
    cfg_t drv;

    logic [HW-1:0] h_pos;
    logic [VW-1:0] v_pos;
    logic de, hsync, vsync, field, sof;

    int checks = 0;
    int errors = 0;

    always #(CLK_P/2) clk = ~clk;

    raster_timing_gen #(.HW(HW), .VW(VW)) u_raster_timing_gen (
        .clk              (clk),
        .rst_n            (rst_n),
        .cfg_h_total      (HW'(drv.ht)),
        .cfg_h_act_start  (HW'(drv.act)),
        .cfg_hs_start     (HW'(drv.hs_on)),
        .cfg_hs_end       (HW'(drv.hs_off)),
        .cfg_vs1_on_col   (HW'(drv.v1oh)),
        .cfg_vs1_off_col  (HW'(drv.v1fh)),
        .cfg_vs2_on_col   (HW'(drv.v2oh)),
        .cfg_vs2_off_col  (HW'(drv.v2fh)),
        .cfg_v_total      (VW'(drv.vt)),
        .cfg_vb1_start    (VW'(drv.b1s)),
        .cfg_vb1_end      (VW'(drv.b1e)),
        .cfg_vb2_start    (VW'(drv.b2s)),
        .cfg_vb2_end      (VW'(drv.b2e)),
        .cfg_f1_first     (VW'(drv.f1)),
        .cfg_f2_first     (VW'(drv.f2)),
        .cfg_vs1_on_line  (VW'(drv.v1ov)),
        .cfg_vs1_off_line (VW'(drv.v1fv)),
        .cfg_vs2_on_line  (VW'(drv.v2ov)),
        .cfg_vs2_off_line (VW'(drv.v2fv)),
        .cfg_progressive  (drv.prog[0]),
        .cfg_commit       (commit),
        .h_pos            (h_pos),
        .v_pos            (v_pos),
        .de               (de),
        .hsync            (hsync),
        .vsync            (vsync),
        .field            (field),
        .sof              (sof)
    );

    function automatic cfg_t mk(int ht, int vt, int act, int hs_on, int hs_off,
                                int b1s, int b1e, int b2s, int b2e, int f1, int f2,
                                int v1oh, int v1ov, int v1fh, int v1fv,
                                int v2oh, int v2ov, int v2fh, int v2fv, int prog);
        cfg_t c;
        c.ht = ht; c.vt = vt; c.act = act; c.hs_on = hs_on; c.hs_off = hs_off;
        c.b1s = b1s; c.b1e = b1e; c.b2s = b2s; c.b2e = b2e; c.f1 = f1; c.f2 = f2;
        c.v1oh = v1oh; c.v1ov = v1ov; c.v1fh = v1fh; c.v1fv = v1fv;
        c.v2oh = v2oh; c.v2ov = v2ov; c.v2fh = v2fh; c.v2fv = v2fv; c.prog = prog;
        return c;
    endfunction

    // Reference model state
    bit   m_run = 1'b0;
    int   m_h = 0;
    int   m_v = 0;
    bit   m_pv = 1'b0;
    bit   m_end;
    cfg_t m_work = '0;
    cfg_t m_pend = '0;
    bit   started = 1'b0;
    exp_t q[$];
    exp_t got;

    // Model update per R1..R3, R9, R10
    always @(posedge clk) begin
        started <= 1'b1;
        if (!rst_n) begin
            m_run <= 1'b0; m_h <= 0; m_v <= 0; m_pv <= 1'b0;
        end else if (!m_run) begin
            if (commit) begin
                m_work <= drv; m_run <= 1'b1;
            end
        end else begin
            m_end = (m_h == m_work.ht - 1) && (m_v == m_work.vt - 1);
            if (m_h == m_work.ht - 1) begin
                m_h <= 0;
                m_v <= (m_v == m_work.vt - 1) ? 0 : m_v + 1;
            end else begin
                m_h <= m_h + 1;
            end
            if (m_end && m_pv) begin
                m_work <= m_pend; m_pv <= 1'b0;
            end
            if (commit) begin
                m_pend <= drv; m_pv <= 1'b1;
            end
        end
    end

    function automatic bit in_win(int h, int v, int onh, int onv, int offh, int offv);
        return ((v > onv) || (v == onv && h >= onh)) && ((v < offv) || (v == offv && h < offh));
    endfunction

    function automatic exp_t model_out();
        exp_t e;
        bit vb;
        bit il;
        il    = (m_work.prog == 0);
        vb    = (m_v >= m_work.b1s && m_v < m_work.b1e) ||
                (il && m_v >= m_work.b2s && m_v < m_work.b2e);
        e.h   = m_h;
        e.v   = m_v;
        e.de  = m_run && (m_h >= m_work.act) && !vb;
        e.hs  = m_run && (m_h >= m_work.hs_on) && (m_h < m_work.hs_off);
        e.vs  = m_run && (in_win(m_h, m_v, m_work.v1oh, m_work.v1ov, m_work.v1fh, m_work.v1fv) ||
                (il && in_win(m_h, m_v, m_work.v2oh, m_work.v2ov, m_work.v2fh, m_work.v2fv)));
        e.fld = m_run && il && ((m_v >= m_work.f2) || (m_v < m_work.f1));
        e.sof = m_run && (m_h == 0) && (m_v == 0);
        return e;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
        end
    endtask

    // Driver side of the scoreboard: expected outputs of this cycle
    always @(negedge clk) begin
        if (started) q.push_back(model_out());
    end

    // Monitor: pop and compare, away from the active edge
    always @(negedge clk) begin
        #1;
        if (q.size() > 0) begin
            got = q.pop_front();
            chk(int'(h_pos) == got.h, "R3 h_pos", int'(h_pos), got.h);
            chk(int'(v_pos) == got.v, "R3 v_pos", int'(v_pos), got.v);
            chk(sof == got.sof,       "R3 sof",   int'(sof),   int'(got.sof));
            chk(de == got.de,         "R4 R5 de", int'(de),    int'(got.de));
            chk(hsync == got.hs,      "R6 hsync", int'(hsync), int'(got.hs));
            chk(vsync == got.vs,      "R7 vsync", int'(vsync), int'(got.vs));
            chk(field == got.fld,     "R8 field", int'(field), int'(got.fld));
        end
    end

    task automatic do_commit(cfg_t c);
        drv = c; commit = 1'b1;
        @(negedge clk);
        commit = 1'b0;
    endtask

    task automatic measure_frame(output int n);
        while (!sof) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sof);
    endtask

    task automatic wait_end(int ht, int vt);
        while (!(int'(h_pos) == ht - 1 && int'(v_pos) == vt - 1)) @(negedge clk);
    endtask

    initial begin
        cfg_t ca, cb, cc;
        int n;
        ca = mk(12, 10, 3, 1, 3, 0, 2, 5, 7, 0, 5, 6, 0, 6, 1, 4, 5, 2, 6, 0);
        cb = mk(9, 7, 2, 0, 2, 6, 7, 0, 3, 0, 3, 2, 6, 5, 6, 0, 0, 8, 2, 1);
        cc = mk(10, 8, 4, 7, 9, 0, 1, 4, 5, 0, 4, 5, 0, 5, 1, 0, 4, 9, 4, 0);
        drv = ca;
        repeat (3) @(negedge clk);
        // R1: state while reset is low
        chk(h_pos == '0 && v_pos == '0 && !sof && !de && !hsync && !vsync && !field,
            "R1 in reset", int'(h_pos), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        chk(h_pos == '0 && !sof && !de, "R1 idle after reset", int'(h_pos), 0);
        // R9: input changes with no commit leave the idle state alone
        drv = cb;
        repeat (5) @(negedge clk);
        chk(h_pos == '0 && !sof && !hsync, "R9 idle ignores inputs", int'(sof), 0);
        // R2: first commit starts at once
        do_commit(ca);
        chk(sof == 1'b1 && h_pos == '0 && v_pos == '0, "R2 first sof", int'(sof), 1);
        repeat (240) @(negedge clk);
        // R9: new inputs without commit, raster keeps its size
        drv = cb;
        measure_frame(n);
        chk(n == 120, "R9 frame length", n, 120);
        measure_frame(n);
        chk(n == 120, "R9 frame length again", n, 120);
        // R10: two commits mid-frame, last one wins at the boundary
        repeat (30) @(negedge clk);
        do_commit(cb);
        repeat (5) @(negedge clk);
        do_commit(cc);
        measure_frame(n);
        chk(n == 80, "R10 last commit wins", n, 80);
        measure_frame(n);
        chk(n == 80, "R10 settings persist", n, 80);
        // R10: pending swap and new commit on the same last pixel
        repeat (20) @(negedge clk);
        do_commit(ca);
        wait_end(cc.ht, cc.vt);
        do_commit(cb);
        measure_frame(n);
        chk(n == 120, "R10 pending applied at boundary", n, 120);
        measure_frame(n);
        chk(n == 63, "R10 last-pixel commit one frame later", n, 63);
        repeat (70) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule